// File: doc/BRIEF.md
# Segmented Address Generation Unit

This block turns a 16-bit segment value and an offset into a 32-bit linear address. It works in one of two modes, and the mode input picks the mode for each request. In real mode the segment value is multiplied by sixteen and added to the offset, with no checks.

In protected mode the segment value is a selector. The selector names one entry in one of two small on-chip descriptor tables. One table is global and the other is local. The chosen descriptor gives a base address, a byte limit, a present bit and a writable bit. The unit adds the base to the offset and checks the access against the descriptor. Any violation is reported on a fault flag, and the address output is zeroed.

Both tables are filled through a synchronous write port. A translation result appears on registered outputs one cycle after the request.

Top module: `seg_addr_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `out_valid`, `out_addr` and all four fault flags are 0.
- R2: `out_valid` is 1 in the cycle after a cycle with `req_valid` high, and 0 in the cycle after a cycle with `req_valid` low. The result belongs to the request of the previous cycle.
- R3: With `req_prot`=0 (real mode), `out_addr` = (`req_seg` * 16 + `req_off`) mod 2^32, and no fault flag is raised, whatever the selector bits are.
- R4: In protected mode the selector bits are decoded as follows:
  - Bits [1:0] are the requested privilege level, and they do not change the result.
  - Bit [2] picks the table: 0 is global, 1 is local.
  - Bits [15:3] are the entry index.
- R5: A 64-bit descriptor word is laid out as follows:
  - Bits [31:0] hold the base.
  - Bits [51:32] hold the byte limit.
  - Bit [52] is the present bit.
  - Bit [53] is the writable bit.
  - The remaining bits are ignored.
  A request that raises no fault returns `out_addr` = base + offset (mod 2^32).
- R6: `out_flt_lim` is raised when the offset is greater than the limit. An offset equal to the limit raises no fault.
- R7: `out_flt_np` is raised when the present bit is 0. When it is raised, the limit fault and the write fault are both held at 0.
- R8: `out_flt_wp` is raised on a request with `req_write`=1 to a descriptor whose writable bit is 0. A read of such a segment raises no fault.
- R9: `out_flt_idx` is raised when the index is not below the table depth (16). When it is raised, all other fault flags are 0.
- R10: Whenever any fault flag is 1, `out_addr` is 0.
- R11: A cycle with `tbl_we`=1 stores `tbl_data` into entry `tbl_idx` of the table chosen by `tbl_local` (0 global, 1 local). The same entry of the other table keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request this cycle |
| req_prot | input | 1 | 1 = protected mode, 0 = real mode |
| req_write | input | 1 | Access is a write |
| req_seg | input | 16 | Segment value or selector |
| req_off | input | 32 | Offset within segment |
| tbl_we | input | 1 | Descriptor write enable |
| tbl_local | input | 1 | Write target: 0 global, 1 local table |
| tbl_idx | input | 4 | Entry written |
| tbl_data | input | 64 | Descriptor word written |
| out_valid | output | 1 | Result valid |
| out_addr | output | 32 | Linear address (0 on fault) |
| out_flt_idx | output | 1 | Index beyond table depth |
| out_flt_np | output | 1 | Descriptor not present |
| out_flt_lim | output | 1 | Offset beyond limit |
| out_flt_wp | output | 1 | Write to read-only segment |

## Verification
The bench fills both tables and then sweeps every entry of each table. Each entry is tried under every privilege level and under both read and write. It uses three offsets per entry: zero, exactly the limit, and one past the limit.

Three faults in a design would show up in this sweep:
- A compare of greater-or-equal in place of greater-than would fault at the exact limit.
- A swapped table-indicator sense would return the other table's base.
- Decoding the index from the wrong bits would make the address depend on the privilege level.

Real mode is probed where carries matter: segment 0xFFFF, and an all-ones offset that wraps past 2^32.

The bench also covers out-of-range indices and a rewrite of one table's entry. A unit that missed the fault priority would raise a limit fault on a segment that is not present. A unit that missed the table select would let the rewrite corrupt the other table.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

  localparam int LIN_W  = 32;
  localparam int LIM_W  = 20;
  localparam int DESC_W = 64;
  localparam int SEG_W  = 16;

  localparam int LIM_LO  = 32;
  localparam int PRES_B  = 52;
  localparam int WRITE_B = 53;

  typedef struct packed {
    logic             writable;
    logic             present;
    logic [LIM_W-1:0] limit;
    logic [LIN_W-1:0] base;
  } desc_t;

  typedef struct packed {
    logic idx;
    logic np;
    logic lim;
    logic wp;
  } fault_t;

  function automatic desc_t unpack_desc(input logic [DESC_W-1:0] w);
    desc_t d;
    d.base     = w[LIN_W-1:0];
    d.limit    = w[LIM_LO +: LIM_W];
    d.present  = w[PRES_B];
    d.writable = w[WRITE_B];
    return d;
  endfunction

endpackage

// File: rtl/seg_desc_ram.sv
module seg_desc_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/seg_prot_check.sv
module seg_prot_check
  import seg_addr_pkg::*;
(
  input  desc_t            desc,
  input  logic [LIN_W-1:0] off,
  input  logic             is_write,
  input  logic             in_range,
  output fault_t           flt,
  output logic [LIN_W-1:0] addr
);

  logic [LIN_W-1:0] lim_ext;

  always_comb begin
    lim_ext = {{(LIN_W-LIM_W){1'b0}}, desc.limit};
    flt     = '0;
    if (!in_range) begin
      flt.idx = 1'b1;
    end else if (!desc.present) begin
      flt.np = 1'b1;
    end else begin
      flt.lim = (off > lim_ext);
      flt.wp  = is_write && !desc.writable;
    end
    addr = desc.base + off;
  end

endmodule

// File: rtl/seg_real_base.sv
module seg_real_base
  import seg_addr_pkg::*;
(
  input  logic [SEG_W-1:0] seg,
  input  logic [LIN_W-1:0] off,
  output logic [LIN_W-1:0] addr
);

  localparam int PAD = LIN_W - SEG_W - 4;

  logic [LIN_W-1:0] base;

  always_comb begin
    base = {{PAD{1'b0}}, seg, 4'b0000};
    addr = base + off;
  end

endmodule

// File: rtl/seg_addr_unit.sv
module seg_addr_unit
  import seg_addr_pkg::*;
#(
  parameter int TBL_DEPTH = 16,
  localparam int IDX_W = $clog2(TBL_DEPTH),
  localparam int SEL_IDX_W = SEG_W - 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_prot,
  input  logic              req_write,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [LIN_W-1:0]  req_off,
  input  logic              tbl_we,
  input  logic              tbl_local,
  input  logic [IDX_W-1:0]  tbl_idx,
  input  logic [DESC_W-1:0] tbl_data,
  output logic              out_valid,
  output logic [LIN_W-1:0]  out_addr,
  output logic              out_flt_idx,
  output logic              out_flt_np,
  output logic              out_flt_lim,
  output logic              out_flt_wp
);

  // Selector decode: [1:0] privilege request, [2] table pick, [15:3] index
  logic [SEL_IDX_W-1:0] sel_index;
  logic                 sel_local;
  logic                 sel_in_range;
  logic [IDX_W-1:0]     rd_idx;

  assign sel_index    = req_seg[SEG_W-1:3];
  assign sel_local    = req_seg[2];
  assign sel_in_range = (sel_index < SEL_IDX_W'(TBL_DEPTH));
  assign rd_idx       = sel_index[IDX_W-1:0];

  logic [DESC_W-1:0] rd_word [2];

  for (genvar t = 0; t < 2; t++) begin : g_tbl
    logic wr_here;
    assign wr_here = tbl_we && ((t == 1) ? tbl_local : !tbl_local);
    seg_desc_ram #(.DEPTH(TBL_DEPTH), .WIDTH(DESC_W)) u_ram (
      .clk  (clk),
      .we   (wr_here),
      .waddr(tbl_idx),
      .wdata(tbl_data),
      .raddr(rd_idx),
      .rdata(rd_word[t])
    );
  end

  desc_t            cur_desc;
  fault_t           prot_flt;
  logic [LIN_W-1:0] prot_addr;
  logic [LIN_W-1:0] real_addr;

  assign cur_desc = unpack_desc(sel_local ? rd_word[1] : rd_word[0]);

  seg_prot_check u_chk (
    .desc    (cur_desc),
    .off     (req_off),
    .is_write(req_write),
    .in_range(sel_in_range),
    .flt     (prot_flt),
    .addr    (prot_addr)
  );

  seg_real_base u_real (
    .seg (req_seg),
    .off (req_off),
    .addr(real_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_addr    <= '0;
      out_flt_idx <= 1'b0;
      out_flt_np  <= 1'b0;
      out_flt_lim <= 1'b0;
      out_flt_wp  <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        if (req_prot) begin
          out_flt_idx <= prot_flt.idx;
          out_flt_np  <= prot_flt.np;
          out_flt_lim <= prot_flt.lim;
          out_flt_wp  <= prot_flt.wp;
          out_addr    <= (|prot_flt) ? '0 : prot_addr;
        end else begin
          out_flt_idx <= 1'b0;
          out_flt_np  <= 1'b0;
          out_flt_lim <= 1'b0;
          out_flt_wp  <= 1'b0;
          out_addr    <= real_addr;
        end
      end
    end
  end

  // R2: one-cycle latency on valid
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);
  p_idle_follows_r2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);

  // R3: real mode never faults
  p_real_no_fault_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_prot) |=>
      !(out_flt_idx || out_flt_np || out_flt_lim || out_flt_wp));

  // R7: not-present suppresses limit and write faults
  p_np_alone_r7: assert property (@(posedge clk) disable iff (rst)
    out_flt_np |-> !(out_flt_lim || out_flt_wp));

  // R8: reads never raise write-protection
  p_read_no_wp_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> !out_flt_wp);

  // R9: index fault stands alone
  p_idx_alone_r9: assert property (@(posedge clk) disable iff (rst)
    out_flt_idx |-> !(out_flt_np || out_flt_lim || out_flt_wp));

  // R10: no address while faulted
  p_zero_on_fault_r10: assert property (@(posedge clk) disable iff (rst)
    (out_flt_idx || out_flt_np || out_flt_lim || out_flt_wp) |-> (out_addr == '0));

endmodule

// File: tb/seg_addr_unit_bench.sv
module seg_addr_unit_bench;
  import seg_addr_pkg::*;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_prot, req_write;
  logic [15:0] req_seg;
  logic [31:0] req_off;
  logic        tbl_we, tbl_local;
  logic [3:0]  tbl_idx;
  logic [63:0] tbl_data;
  logic        out_valid;
  logic [31:0] out_addr;
  logic        out_flt_idx, out_flt_np, out_flt_lim, out_flt_wp;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  seg_addr_unit u_seg_addr_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_prot(req_prot),
    .req_write(req_write), .req_seg(req_seg), .req_off(req_off),
    .tbl_we(tbl_we), .tbl_local(tbl_local), .tbl_idx(tbl_idx),
    .tbl_data(tbl_data), .out_valid(out_valid), .out_addr(out_addr),
    .out_flt_idx(out_flt_idx), .out_flt_np(out_flt_np),
    .out_flt_lim(out_flt_lim), .out_flt_wp(out_flt_wp)
  );

  // descriptor contents, computed from the entry number
  function automatic logic [31:0] f_base(input int t, input int i);
    return (t == 0) ? 32'h1000_0000 + 32'(i) * 32'h0001_0100
                    : 32'h8000_0000 ^ (32'(i) << 20);
  endfunction
  function automatic logic [19:0] f_lim(input int t, input int i);
    return (t == 0) ? 20'(i * 'h111 + 3) : 20'(i * 'h2000 + 'hFF);
  endfunction
  function automatic bit f_pres(input int t, input int i);
    return (t == 0) ? (i != 5) : (i != 9);
  endfunction
  function automatic bit f_wr(input int t, input int i);
    return (t == 0) ? (i % 3 != 0) : (i % 2 == 0);
  endfunction
  function automatic logic [63:0] f_word(input int t, input int i);
    logic [63:0] w;
    w = '0;
    w[31:0]  = f_base(t, i);
    w[51:32] = f_lim(t, i);
    w[52]    = f_pres(t, i);
    w[53]    = f_wr(t, i);
    w[63:54] = 10'h3A5;  // ignored bits
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_desc(input bit loc, input int i, input logic [63:0] w);
    @(negedge clk);
    tbl_we = 1'b1; tbl_local = loc; tbl_idx = 4'(i); tbl_data = w;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // issue one request, compare the result one cycle later
  task automatic xlate(input string req, input bit prot, input bit wr,
                       input logic [15:0] seg, input logic [31:0] off,
                       input logic [31:0] exp_addr, input logic [3:0] exp_flt);
    @(negedge clk);
    req_valid = 1'b1; req_prot = prot; req_write = wr; req_seg = seg; req_off = off;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " valid"}, 32'(out_valid), 32'd1);
    check({req, " addr"}, out_addr, exp_addr);
    check({req, " faults"}, 32'({out_flt_idx, out_flt_np, out_flt_lim, out_flt_wp}),
          32'(exp_flt));
  endtask

  task automatic prot_case(input int t, input int i, input int rpl, input bit wr,
                           input logic [31:0] off, input logic [63:0] w);
    logic [3:0]  ef;
    logic [31:0] ea;
    logic [15:0] seg;
    seg = 16'((i << 3) | (t << 2) | rpl);
    ef = '0;
    if (!w[52]) ef[2] = 1'b1;
    else begin
      ef[1] = (off > {12'd0, w[51:32]});
      ef[0] = wr && !w[53];
    end
    ea = (ef != 0) ? 32'd0 : w[31:0] + off;
    xlate("R4/R5/R6/R7/R8/R10 prot", 1'b1, wr, seg, off, ea, ef);
  endtask

  initial begin
    rst = 1'b1; req_valid = 0; req_prot = 0; req_write = 0; req_seg = 0; req_off = 0;
    tbl_we = 0; tbl_local = 0; tbl_idx = 0; tbl_data = 0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", 32'(out_valid), 0);
    check("R1 addr in reset", out_addr, 0);
    check("R1 faults in reset",
          32'({out_flt_idx, out_flt_np, out_flt_lim, out_flt_wp}), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", 32'(out_valid), 0);

    // R11: fill both tables
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < 16; i++) wr_desc(t[0], i, f_word(t, i));

    // R2: idle cycle keeps valid low
    @(negedge clk);
    check("R2 idle valid", 32'(out_valid), 0);

    // R3: real mode
    begin
      logic [15:0] segs [5] = '{16'h0000, 16'h0001, 16'h1234, 16'hFFFF, 16'h0007};
      logic [31:0] offs [4] = '{32'h0, 32'hF, 32'hFFFF, 32'hFFFF_FFFF};
      for (int a = 0; a < 5; a++)
        for (int b = 0; b < 4; b++)
          xlate("R3 real", 1'b0, b[0], segs[a], offs[b],
                ({12'd0, segs[a], 4'd0} + offs[b]), 4'd0);
    end
    @(negedge clk);
    check("R2 valid drops", 32'(out_valid), 0);

    // R4..R8, R10 sweep
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < 16; i++)
        for (int rpl = 0; rpl < 4; rpl++)
          for (int wr = 0; wr < 2; wr++) begin
            logic [31:0] lim;
            lim = {12'd0, f_lim(t, i)};
            prot_case(t, i, rpl, wr[0], 32'd0, f_word(t, i));
            prot_case(t, i, rpl, wr[0], lim, f_word(t, i));
            prot_case(t, i, rpl, wr[0], lim + 1, f_word(t, i));
          end

    // R9: index beyond depth
    begin
      logic [12:0] bad [4] = '{13'd16, 13'd17, 13'd100, 13'h1FFF};
      for (int k = 0; k < 4; k++)
        for (int t = 0; t < 2; t++)
          xlate("R9 idx", 1'b1, 1'b1, {bad[k], t[0], 2'd1}, 32'd0, 32'd0, 4'b1000);
    end

    // R11: rewriting one global entry leaves the local one unchanged
    wr_desc(1'b0, 2, {10'd0, 1'b1, 1'b1, 20'hFFFFF, 32'hCAFE_0000});
    xlate("R11 global rewritten", 1'b1, 1'b1, 16'h0010, 32'h10, 32'hCAFE_0010, 4'd0);
    prot_case(1, 2, 0, 1'b0, 32'h20, f_word(1, 2));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule